// File: doc/BRIEF.md
# SM3 Compression Engine

This block computes the SM3 compression function on one 512-bit message block at a time. It uses one round per clock. The caller supplies the block as sixteen big-endian 32-bit words and pulses `start`. The engine then runs 64 rounds against a private copy of the chaining value. At the end it folds the result back into the chaining register with an XOR and raises `done` for one cycle. The chaining register drives the `digest` output directly. Successive blocks therefore chain without any extra data movement.

A separate `init` input returns the chaining register to the fixed SM3 starting value. When `init` is raised together with `start`, the block is hashed from the starting value. When `init` is raised alone while the engine is idle, it only reloads that value. Padding, length counting and message framing are left to the surrounding logic. Message words are expanded during the run from a 16-word sliding window, which stays four words ahead of the round index.

Top module: `sm3_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `digest` equals the starting value 7380166F 4914B2B9 172442D7 DA8A0600 A96F30BC 163138AA E38DEE4D B0FB0E4E (word A in bits 255:224, word H in bits 31:0).
- R2: Message word 0 is taken from `block[511:480]` and word 15 from `block[31:0]`, each with its most significant byte first. The digest places word A at bits 255:224 through word H at bits 31:0.
- R3: The padded one-block message "abc", hashed from the starting value, yields 66C7F0F4 62EEEDD9 D1F2D46B DC10E4E2 4167C487 5CF2F7A2 297DA02B 8F4BA8E0.
- R4: A `start` without `init` uses the current `digest` as the chaining input. Two blocks of "abcd" repeated 16 times followed by its padding block yield DEBE9FF9 2275B8A1 38604889 C18E5A4D 6FDB70E5 387E5765 293DCBA3 9C0C5732.
- R5: When `init` and `start` are both high while idle, the block is hashed from the starting value, whatever the previous digest was.
- R6: When `init` is high while idle and `start` is low, `digest` becomes the starting value on the next cycle and `busy` stays 0.
- R7: A `start` pulse while `busy` is high is ignored, and the running block finishes with its own result.
- R8: An `init` pulse while `busy` is high is ignored.
- R9: `busy` is high from the cycle after the accepting edge until `done` rises. `done` rises 65 clock edges after the edge that accepts `start`.
- R10: `done` is high for exactly one cycle, and `digest` holds its value from then until the next accepted `start` or `init`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Reload the starting chaining value (honoured only while idle) |
| start | input | 1 | Begin compressing `block` (honoured only while idle) |
| block | input | 512 | Message block, word 0 in the top 32 bits |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when `digest` has been updated |
| digest | output | 256 | Chaining value, words A to H from the top |

## Verification
The function is driven with three kinds of block. The first is a short padded message that is mostly zero words with a small length field. The second is a dense block of a repeated four-byte pattern, which is hashed from the starting value. The third is a padding block hashed on top of that result. The first kind shows that byte order and both round-function phases are right. The second and third kinds show that the chaining input is reused and that window expansion works on dense data. Running the short message again after the chain has changed separates a true `init` override from a stale chaining value. Pulses on `start` and `init` injected in the middle of a run, on top of a non-initial chain, show whether either one can disturb a block that is in progress.

// File: rtl/sm3_pkg.sv
package sm3_pkg;
  localparam int WORD_W     = 32;
  localparam int BLK_WORDS  = 16;
  localparam int ST_WORDS   = 8;
  localparam int ROUNDS     = 64;
  localparam int SWITCH_RND = 16;
  localparam int BLK_W      = BLK_WORDS * WORD_W;
  localparam int ST_W       = ST_WORDS * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a; word_t b; word_t c; word_t d;
    word_t e; word_t f; word_t g; word_t h;
  } state_t;

  localparam state_t IV = '{
    a: 32'h7380166F, b: 32'h4914B2B9, c: 32'h172442D7, d: 32'hDA8A0600,
    e: 32'hA96F30BC, f: 32'h163138AA, g: 32'hE38DEE4D, h: 32'hB0FB0E4E
  };

  localparam word_t T_EARLY = 32'h79CC4519;
  localparam word_t T_LATE  = 32'h7A879D8A;

  function automatic word_t rotl(input word_t x, input logic [4:0] n);
    if (n == 5'd0) return x;
    return (x << n) | (x >> (6'd32 - {1'b0, n}));
  endfunction

  function automatic word_t perm0(input word_t x);
    return x ^ rotl(x, 5'd9) ^ rotl(x, 5'd17);
  endfunction

  function automatic word_t perm1(input word_t x);
    return x ^ rotl(x, 5'd15) ^ rotl(x, 5'd23);
  endfunction

  function automatic word_t bool_ff(input word_t x, input word_t y, input word_t z, input logic late);
    return late ? ((x & y) | ((x | y) & z)) : (x ^ y ^ z);
  endfunction

  function automatic word_t bool_gg(input word_t x, input word_t y, input word_t z, input logic late);
    return late ? (z ^ (x & (y ^ z))) : (x ^ y ^ z);
  endfunction
endpackage

// File: rtl/sm3_msg_sched.sv
module sm3_msg_sched
  import sm3_pkg::*;
#(
  parameter int WIN  = BLK_WORDS,
  parameter int LEAD = 4,
  localparam int IN_W = WIN * WORD_W
) (
  input  logic            clk,
  input  logic            load,
  input  logic            shift,
  input  logic [IN_W-1:0] blk,
  output word_t           w_cur,
  output word_t           w_lead
);
  word_t win [WIN];
  word_t nxt;

  always_comb begin
    nxt = perm1(win[0] ^ win[7] ^ rotl(win[13], 5'd15)) ^ rotl(win[3], 5'd7) ^ win[10];
  end

  genvar gi;
  generate
    for (gi = 0; gi < WIN; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (load) begin
          win[gi] <= blk[(WIN-1-gi)*WORD_W +: WORD_W];
        end else if (shift) begin
          if (gi == WIN-1) win[gi] <= nxt;
          else             win[gi] <= win[(gi+1) % WIN];
        end
      end
    end
  endgenerate

  assign w_cur  = win[0];
  assign w_lead = win[LEAD];
endmodule

// File: rtl/sm3_round.sv
module sm3_round
  import sm3_pkg::*;
(
  input  state_t st,
  input  word_t  wj,
  input  word_t  wpj,
  input  word_t  tj,
  input  logic   late,
  output state_t nx
);
  word_t a12, ss1, ss2, tt1, tt2;

  always_comb begin
    a12 = rotl(st.a, 5'd12);
    ss1 = rotl(a12 + st.e + tj, 5'd7);
    ss2 = ss1 ^ a12;
    tt1 = bool_ff(st.a, st.b, st.c, late) + st.d + ss2 + wpj;
    tt2 = bool_gg(st.e, st.f, st.g, late) + st.h + ss1 + wj;
    nx.a = tt1;
    nx.b = st.a;
    nx.c = rotl(st.b, 5'd9);
    nx.d = st.c;
    nx.e = perm0(tt2);
    nx.f = st.e;
    nx.g = rotl(st.f, 5'd19);
    nx.h = st.g;
  end
endmodule

// File: rtl/sm3_ctrl.sv
module sm3_ctrl
  import sm3_pkg::*;
#(
  parameter int NRND = ROUNDS,
  localparam int CW = $clog2(NRND)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          accept,
  output logic          run,
  output logic          fin,
  output logic [CW-1:0] rnd
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} phase_t;
  phase_t phase;

  assign busy   = (phase != S_IDLE);
  assign accept = (phase == S_IDLE) && start;
  assign run    = (phase == S_RUN);
  assign fin    = (phase == S_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= S_IDLE;
      rnd   <= '0;
      done  <= 1'b0;
    end else begin
      done <= fin;
      case (phase)
        S_IDLE: if (start) begin
          phase <= S_RUN;
          rnd   <= '0;
        end
        S_RUN: begin
          rnd <= rnd + 1'b1;
          if (rnd == CW'(NRND-1)) phase <= S_FIN;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sm3_core.sv
module sm3_core
  import sm3_pkg::*;
#(
  parameter int NRND = ROUNDS,
  localparam int CW = $clog2(NRND)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             start,
  input  logic [BLK_W-1:0] block,
  output logic             busy,
  output logic             done,
  output logic [ST_W-1:0]  digest
);
  state_t chain, work, nx, chain_src;
  logic accept, run, fin, late;
  logic [CW-1:0] rnd;
  word_t w_cur, w_lead, tj;

  sm3_ctrl #(.NRND(NRND)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .accept(accept), .run(run), .fin(fin), .rnd(rnd)
  );

  sm3_msg_sched #(.WIN(BLK_WORDS), .LEAD(4)) u_sched (
    .clk(clk), .load(accept), .shift(run), .blk(block),
    .w_cur(w_cur), .w_lead(w_lead)
  );

  always_comb begin
    late = (rnd >= CW'(SWITCH_RND));
    tj   = rotl(late ? T_LATE : T_EARLY, rnd[4:0]);
  end

  sm3_round u_round (
    .st(work), .wj(w_cur), .wpj(w_cur ^ w_lead), .tj(tj), .late(late), .nx(nx)
  );

  assign chain_src = init ? IV : chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= IV;
      work  <= '0;
    end else if (accept) begin
      chain <= chain_src;
      work  <= chain_src;
    end else if (!busy && init) begin
      chain <= IV;
    end else if (run) begin
      work <= nx;
    end else if (fin) begin
      chain <= chain ^ work;
    end
  end

  assign digest = chain;
endmodule

// File: rtl/sm3_core_chk.sv
module sm3_core_chk
  import sm3_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            init,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [ST_W-1:0] digest
);
  logic [7:0] since;

  always_ff @(posedge clk) begin
    if (rst)                 since <= '0;
    else if (start && !busy) since <= '0;
    else if (since != 8'hFF) since <= since + 1'b1;
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);

  // R9
  done_latency_chk: assert property (@(posedge clk) disable iff (rst) done |-> (since == 8'd65));

  // R7
  run_digest_chk: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(digest));

  // R6
  init_load_chk: assert property (@(posedge clk) disable iff (rst) (!busy && init && !start) |=> (digest == IV && !busy));
endmodule

bind sm3_core sm3_core_chk u_chk (
  .clk(clk), .rst(rst), .init(init), .start(start),
  .busy(busy), .done(done), .digest(digest)
);

// File: tb/sim_sm3_core.sv
`timescale 1ns/1ps
module sim_sm3_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init = 1'b0;
  logic start = 1'b0;
  logic [511:0] block = '0;
  logic busy, done;
  logic [255:0] digest;

  int n_chk = 0;
  int n_bad = 0;
  int wd = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sm3_core u0 (
    .clk(clk), .rst(rst), .init(init), .start(start), .block(block),
    .busy(busy), .done(done), .digest(digest)
  );

  localparam logic [255:0] START_VAL = 256'h7380166F_4914B2B9_172442D7_DA8A0600_A96F30BC_163138AA_E38DEE4D_B0FB0E4E;
  localparam logic [255:0] ABC_DIG   = 256'h66C7F0F4_62EEEDD9_D1F2D46B_DC10E4E2_4167C487_5CF2F7A2_297DA02B_8F4BA8E0;
  localparam logic [255:0] TWO_DIG   = 256'hDEBE9FF9_2275B8A1_38604889_C18E5A4D_6FDB70E5_387E5765_293DCBA3_9C0C5732;
  localparam logic [511:0] BLK_ABC   = {32'h61626380, {14{32'h0}}, 32'h00000018};
  localparam logic [511:0] BLK_DENSE = {16{32'h61626364}};
  localparam logic [511:0] BLK_PAD   = {32'h80000000, {14{32'h0}}, 32'h00000200};

  localparam int NV = 4;
  localparam logic [511:0] V_BLK [NV] = '{BLK_ABC, BLK_DENSE, BLK_PAD, BLK_ABC};
  localparam bit           V_INI [NV] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam bit           V_CHK [NV] = '{1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [255:0] V_EXP [NV] = '{ABC_DIG, '0, TWO_DIG, ABC_DIG};
  localparam string        V_REQ [NV] = '{"R3", "R4", "R4", "R5"};

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hash(input logic [511:0] b, input bit ini, input int poke,
                      input bit poke_start, input bit poke_init,
                      output int lat, output bit busy_ok);
    int n;
    @(negedge clk);
    block = b; init = ini; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; init = 1'b0;
    n = 0;
    busy_ok = 1'b1;
    while (!done && n < 200) begin
      if (!busy) busy_ok = 1'b0;
      if (n == poke && poke > 0) begin
        start = poke_start; init = poke_init; block = ~b;
      end else begin
        start = 1'b0; init = 1'b0;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    start = 1'b0; init = 1'b0;
    lat = n;
  endtask

  initial begin
    int lat;
    bit bok;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 busy", {255'b0, busy}, 256'd0);
    chk("R1 done", {255'b0, done}, 256'd0);
    chk("R1 digest", digest, START_VAL);

    // Vector table: R2, R3, R4, R5
    for (int i = 0; i < NV; i++) begin
      hash(V_BLK[i], V_INI[i], 0, 1'b0, 1'b0, lat, bok);
      if (V_CHK[i]) chk({V_REQ[i], " R2 digest"}, digest, V_EXP[i]);
      // R9
      chk("R9 latency", 256'(lat), 256'd65);
      chk("R9 busy span", {255'b0, bok}, 256'd1);
    end

    // R10: done lasts one cycle, digest held afterwards
    @(negedge clk);
    chk("R10 done one cycle", {255'b0, done}, 256'd0);
    repeat (5) @(negedge clk);
    chk("R10 digest held", digest, ABC_DIG);

    // R6: init alone while idle
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    chk("R6 digest", digest, START_VAL);
    chk("R6 busy", {255'b0, busy}, 256'd0);

    // R7: start pulse during a run is ignored
    hash(BLK_ABC, 1'b1, 10, 1'b1, 1'b0, lat, bok);
    chk("R7 digest", digest, ABC_DIG);
    chk("R7 latency", 256'(lat), 256'd65);

    // R8: init pulse during a run on a non-initial chain is ignored
    hash(BLK_DENSE, 1'b1, 0, 1'b0, 1'b0, lat, bok);
    hash(BLK_PAD, 1'b0, 20, 1'b0, 1'b1, lat, bok);
    chk("R8 digest", digest, TWO_DIG);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule